// File: doc/BRIEF.md
# Conditional Division Step Unit

This block performs one iteration of a non-restoring division. On each strobe it takes a dividend word and a divisor. It forms a working remainder from the held partial remainder (the Y register) and the top dividend bit. It then adds the divisor to that remainder or subtracts it, choosing by the current sign condition. The block writes back the sum, the four condition flags (negative, zero, overflow, carry) and a dividend word shifted left by one bit that carries the new quotient bit. A controller issues 32 such steps in a row to complete a divide. That sequencing is not part of this block.

The step is legal only while lite mode is enabled. If a step arrives with lite mode off, the block raises a one-cycle unimplemented-instruction trap and changes no state. A separate write strobe loads Y and the flags directly, in the way a processor sets them up before a divide. All updates take effect on a single clock edge.

Top module: `divstep_unit`

## Requirements
- R1: A synchronous reset clears Y, all four flags, the destination write enable and the trap output to zero.
- R2: When `wr_i` is high at a clock edge, Y takes `wr_y_i` and the flags take `wr_flags_i`, where bit 3 is N, bit 2 is Z, bit 1 is V and bit 0 is C. No destination write and no trap occur, and the write wins over a simultaneous step strobe.
- R3: A step (`step_i` high, `lite_i` high, `wr_i` low) computes sign = N xor V and remainder = {Y[W-2:0], rs1[W-1]}. It adds the two's-complement negated divisor when sign is 0, or the unchanged divisor when sign is 1. Y holds this W-bit sum from the next edge on.
- R4: The carry term c0 is the plain carry-out of that W-bit addition, even when the divisor was negated. A negated zero divisor is zero and gives c0 = 0.
- R5: After a step, N equals the sum's top bit. Z is 1 only when the sum is zero and sign equals the old Y top bit.
- R6: After a step, with y31 the old Y top bit, newsign = (sign & ~y31) | (~c0 & (sign | ~y31)). V is newsign xor the sum's top bit, and C is ~newsign.
- R7: After a step, `rd_we_o` equals `rd_nz_i` for one cycle, and `rd_data_o` is {rs1[W-2:0], ~newsign}.
- R8: A step strobe with `lite_i` low raises `trap_o` for one cycle. Y and the flags are left unchanged, and `rd_we_o` stays low.
- R9: In a cycle with neither strobe, Y and the flags hold, and `rd_we_o` and `trap_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| step_i | input | 1 | Perform one division step |
| lite_i | input | 1 | Lite mode enable; the step is legal only when high |
| rs1_i | input | WIDTH | Dividend word |
| divisor_i | input | WIDTH | Divisor operand |
| rd_nz_i | input | 1 | Destination index is nonzero |
| wr_i | input | 1 | Load Y and flags directly |
| wr_y_i | input | WIDTH | Value loaded into Y |
| wr_flags_i | input | 4 | Flags loaded: {N,Z,V,C} |
| y_o | output | WIDTH | Partial remainder register |
| flags_o | output | 4 | Flags {N,Z,V,C} |
| rd_we_o | output | 1 | Destination write enable, one cycle |
| rd_data_o | output | WIDTH | Shifted dividend with quotient bit |
| trap_o | output | 1 | Unimplemented-instruction trap pulse |

## Verification
The bench builds the block with WIDTH = 32 and SPLIT_ADDER = 1. In that variant the sum is made of two 16-bit halves joined by a carry. Random operands, together with all 16 loaded flag patterns and both values of the old Y top bit, therefore exercise the carry across the halves as well as c0. Directed cases cover a zero divisor under both signs, sums that are exactly zero with matching and mismatching Y top bit, a zero destination index, a step with lite mode off, and a write that collides with a step.

// File: rtl/divstep_pkg.sv
package divstep_pkg;
   typedef struct packed {
      logic n;
      logic z;
      logic v;
      logic c;
   } cc_t;
endpackage

// File: rtl/divstep_adder.sv
module divstep_adder #(
   parameter int WIDTH = 32,
   parameter bit SPLIT = 1'b0
) (
   input  logic [WIDTH-1:0] a_i,
   input  logic [WIDTH-1:0] b_i,
   output logic [WIDTH-1:0] sum_o,
   output logic             co_o
);
   localparam int LO_W = WIDTH / 2;
   localparam int HI_W = WIDTH - LO_W;

   generate
      if (SPLIT) begin : g_split
         logic [LO_W:0] lo;
         logic [HI_W:0] hi;
         always_comb begin
            lo = {1'b0, a_i[LO_W-1:0]} + {1'b0, b_i[LO_W-1:0]};
            hi = {1'b0, a_i[WIDTH-1:LO_W]} + {1'b0, b_i[WIDTH-1:LO_W]}
                 + {{HI_W{1'b0}}, lo[LO_W]};
            sum_o = {hi[HI_W-1:0], lo[LO_W-1:0]};
            co_o  = hi[HI_W];
         end
      end else begin : g_flat
         logic [WIDTH:0] full;
         always_comb begin
            full  = {1'b0, a_i} + {1'b0, b_i};
            sum_o = full[WIDTH-1:0];
            co_o  = full[WIDTH];
         end
      end
   endgenerate
endmodule

// File: rtl/divstep_flags.sv
module divstep_flags
   import divstep_pkg::*;
#(
   parameter int WIDTH = 32
) (
   input  logic [WIDTH-1:0] sum_i,
   input  logic             c0_i,
   input  logic             sign_i,
   input  logic             y_top_i,
   output cc_t              cc_o,
   output logic             newsign_o
);
   logic sum_zero;
   logic ns;

   always_comb begin
      sum_zero  = (sum_i == '0);
      ns        = (sign_i & ~y_top_i) | (~c0_i & (sign_i | ~y_top_i));
      newsign_o = ns;
      cc_o.n    = sum_i[WIDTH-1];
      cc_o.z    = sum_zero & (sign_i == y_top_i);
      cc_o.v    = ns ^ sum_i[WIDTH-1];
      cc_o.c    = ~ns;
   end
endmodule

// File: rtl/divstep_unit.sv
module divstep_unit
   import divstep_pkg::*;
#(
   parameter int WIDTH       = 32,
   parameter bit SPLIT_ADDER = 1'b1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             step_i,
   input  logic             lite_i,
   input  logic [WIDTH-1:0] rs1_i,
   input  logic [WIDTH-1:0] divisor_i,
   input  logic             rd_nz_i,
   input  logic             wr_i,
   input  logic [WIDTH-1:0] wr_y_i,
   input  logic [3:0]       wr_flags_i,
   output logic [WIDTH-1:0] y_o,
   output logic [3:0]       flags_o,
   output logic             rd_we_o,
   output logic [WIDTH-1:0] rd_data_o,
   output logic             trap_o
);
   localparam int TOP = WIDTH - 1;

   generate
      if (WIDTH < 4) begin : g_bad_width
         $error("divstep_unit: WIDTH must be at least 4");
      end
   endgenerate

   logic [WIDTH-1:0] y_q;
   cc_t              cc_q;
   logic             sign;
   logic [WIDTH-1:0] remainder;
   logic [WIDTH-1:0] addend;
   logic [WIDTH-1:0] sum;
   logic             c0;
   cc_t              cc_new;
   logic             newsign;
   logic             fire;
   logic             bad_step;
   logic             fire_q;
   logic             idle_q;

   always_comb begin
      sign      = cc_q.n ^ cc_q.v;
      remainder = {y_q[TOP-1:0], rs1_i[TOP]};
      addend    = sign ? divisor_i : (~divisor_i + {{(WIDTH-1){1'b0}}, 1'b1});
      fire      = step_i & lite_i & ~wr_i;
      bad_step  = step_i & ~lite_i & ~wr_i;
   end

   divstep_adder #(.WIDTH(WIDTH), .SPLIT(SPLIT_ADDER)) i_adder (
      .a_i   (remainder),
      .b_i   (addend),
      .sum_o (sum),
      .co_o  (c0)
   );

   divstep_flags #(.WIDTH(WIDTH)) i_flags (
      .sum_i     (sum),
      .c0_i      (c0),
      .sign_i    (sign),
      .y_top_i   (y_q[TOP]),
      .cc_o      (cc_new),
      .newsign_o (newsign)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         y_q       <= '0;
         cc_q      <= '0;
         rd_we_o   <= 1'b0;
         rd_data_o <= '0;
         trap_o    <= 1'b0;
         fire_q    <= 1'b0;
         idle_q    <= 1'b0;
      end else begin
         rd_we_o <= 1'b0;
         trap_o  <= 1'b0;
         fire_q  <= fire;
         idle_q  <= ~step_i & ~wr_i;
         if (wr_i) begin
            y_q  <= wr_y_i;
            cc_q <= cc_t'(wr_flags_i);
         end else if (fire) begin
            y_q       <= sum;
            cc_q      <= cc_new;
            rd_we_o   <= rd_nz_i;
            rd_data_o <= {rs1_i[TOP-1:0], ~newsign};
         end else if (bad_step) begin
            trap_o <= 1'b1;
         end
      end
   end

   assign y_o     = y_q;
   assign flags_o = cc_q;

   AST_TRAP_KEEPS_Y: assert property (@(posedge clk) disable iff (rst)
      trap_o |-> (y_o == $past(y_o) && flags_o == $past(flags_o))); // R8
   AST_TRAP_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
      trap_o |-> !rd_we_o); // R8
   AST_V_FROM_C_N: assert property (@(posedge clk) disable iff (rst)
      fire_q |-> (flags_o[1] == (~flags_o[0] ^ flags_o[3]))); // R6
   AST_Z_MEANS_POS: assert property (@(posedge clk) disable iff (rst)
      (fire_q && flags_o[2]) |-> !flags_o[3]); // R5
   AST_QBIT_IS_C: assert property (@(posedge clk) disable iff (rst)
      rd_we_o |-> (rd_data_o[0] == flags_o[0])); // R7
   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
      idle_q |-> (y_o == $past(y_o) && !rd_we_o && !trap_o)); // R9
endmodule

// File: tb/test_divstep_unit.sv
module test_divstep_unit;
   localparam int W = 32;

   typedef struct {
      logic [W-1:0] y;
      logic [3:0]   f;
      logic         we;
      logic [W-1:0] rd;
      logic         chk_rd;
      logic         trap;
      string        tag;
   } item_t;

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic         step_i = 1'b0, lite_i = 1'b0, rd_nz_i = 1'b0, wr_i = 1'b0;
   logic [W-1:0] rs1_i = '0, divisor_i = '0, wr_y_i = '0;
   logic [3:0]   wr_flags_i = '0;
   logic [W-1:0] y_o, rd_data_o;
   logic [3:0]   flags_o;
   logic         rd_we_o, trap_o;

   int checks = 0;
   int failures = 0;
   item_t q[$];
   logic [W-1:0] m_y = '0;
   logic [3:0]   m_f = '0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   divstep_unit #(.WIDTH(W), .SPLIT_ADDER(1'b1)) i_divstep_unit (
      .clk, .rst, .step_i, .lite_i, .rs1_i, .divisor_i, .rd_nz_i,
      .wr_i, .wr_y_i, .wr_flags_i, .y_o, .flags_o, .rd_we_o, .rd_data_o, .trap_o
   );

   task automatic chk(string req, logic [W-1:0] act, logic [W-1:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s act=%h exp=%h", req, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (q.size() > 0) begin
         item_t e;
         e = q.pop_front();
         chk({e.tag, " y"}, y_o, e.y);
         chk({e.tag, " flags"}, {28'd0, flags_o}, {28'd0, e.f});
         chk({e.tag, " we"}, {31'd0, rd_we_o}, {31'd0, e.we});
         chk({e.tag, " trap"}, {31'd0, trap_o}, {31'd0, e.trap});
         if (e.chk_rd) chk({e.tag, " rd"}, rd_data_o, e.rd);
      end
   end

   task automatic cycle(input logic st, input logic li, input logic [W-1:0] r,
                        input logic [W-1:0] d, input logic nz, input logic wr,
                        input logic [W-1:0] wy, input logic [3:0] wf, input string tag);
      item_t e;
      logic sign, y31, c0, ns;
      logic [W-1:0] rem, add, sum;
      logic [W:0] full;
      @(negedge clk);
      step_i = st; lite_i = li; rs1_i = r; divisor_i = d; rd_nz_i = nz;
      wr_i = wr; wr_y_i = wy; wr_flags_i = wf;
      e.we = 1'b0; e.trap = 1'b0; e.chk_rd = 1'b0; e.rd = '0; e.tag = tag;
      if (wr) begin
         m_y = wy; m_f = wf;
      end else if (st && li) begin
         sign = m_f[3] ^ m_f[1];
         y31  = m_y[W-1];
         rem  = {m_y[W-2:0], r[W-1]};
         add  = sign ? d : (32'd0 - d);
         full = {1'b0, rem} + {1'b0, add};
         sum  = full[W-1:0];
         c0   = full[W];
         ns   = (sign & ~y31) | (~c0 & (sign | ~y31));
         m_f  = {sum[W-1], (sum == 0) && (sign == y31), ns ^ sum[W-1], ~ns};
         m_y  = sum;
         e.we = nz; e.chk_rd = 1'b1; e.rd = {r[W-2:0], ~ns};
      end else if (st) begin
         e.trap = 1'b1;
      end
      @(posedge clk);
      e.y = m_y; e.f = m_f;
      q.push_back(e);
   endtask

   initial begin
      #1_600_000;
      failures++; checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst = 1'b0;
      chk("R1 y", y_o, '0);
      chk("R1 flags", {28'd0, flags_o}, '0);
      chk("R1 we", {31'd0, rd_we_o}, '0);
      chk("R1 trap", {31'd0, trap_o}, '0);
      // R2 load, R9 idle hold
      cycle(0, 0, 0, 0, 0, 1, 32'hdeadbeef, 4'b1010, "R2");
      cycle(0, 1, 0, 0, 1, 0, 0, 0, "R9");
      // R3 R4 R5 R6 R7: all 16 flag patterns, both Y top bits, random operands
      for (int f = 0; f < 16; f++) begin
         for (int k = 0; k < 8; k++) begin
            cycle(0, 0, 0, 0, 0, 1, {k[0], 31'($urandom)}, 4'(f), "R2");
            cycle(1, 1, $urandom, $urandom, k[1], 0, 0, 0, "R3/R4/R5/R6/R7");
         end
      end
      // R4 zero divisor under both signs
      cycle(0, 0, 0, 0, 0, 1, 32'h0000_0005, 4'b0000, "R2");
      cycle(1, 1, 32'h8000_0000, 0, 1, 0, 0, 0, "R4 zero divisor sign0");
      cycle(0, 0, 0, 0, 0, 1, 32'h8000_0005, 4'b1000, "R2");
      cycle(1, 1, 32'h0, 0, 1, 0, 0, 0, "R4 zero divisor sign1");
      // R5 exact-zero sums, matching and mismatching Y top bit
      cycle(0, 0, 0, 0, 0, 1, 32'h0000_0003, 4'b0000, "R2");
      cycle(1, 1, 32'h0, 32'd6, 1, 0, 0, 0, "R5 zero sum y31=0 sign0");
      cycle(0, 0, 0, 0, 0, 1, 32'h8000_0003, 4'b0000, "R2");
      cycle(1, 1, 32'h0, 32'd6, 1, 0, 0, 0, "R5 zero sum y31=1 sign0");
      cycle(0, 0, 0, 0, 0, 1, 32'h8000_0000, 4'b1000, "R2");
      cycle(1, 1, 32'h0, 32'h0, 0, 0, 0, 0, "R5 zero sum y31=1 sign1");
      // R7 zero destination index
      cycle(1, 1, 32'h1234_5678, 32'd9, 0, 0, 0, 0, "R7 rd_nz=0");
      // R8 trap
      cycle(0, 0, 0, 0, 0, 1, 32'h4444_0000, 4'b0110, "R2");
      cycle(1, 0, 32'hffff_ffff, 32'd3, 1, 0, 0, 0, "R8 trap");
      cycle(0, 1, 0, 0, 0, 0, 0, 0, "R9 after trap");
      // R2 write wins over step
      cycle(1, 1, 32'hffff_0000, 32'd7, 1, 1, 32'h0000_1111, 4'b0001, "R2 priority");
      cycle(0, 0, 0, 0, 0, 0, 0, 0, "R9");
      // back-to-back steps
      for (int k = 0; k < 32; k++)
         cycle(1, 1, $urandom, 32'h0001_2345, 1, 0, 0, 0, "R3 chain");
      cycle(0, 0, 0, 0, 0, 0, 0, 0, "R9");
      @(negedge clk);
      @(negedge clk);
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule